// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Status Flags

The block is a serial transmitter with two stages of storage: a holding register that software writes and a shift register that drives the line. Software can write a word through one of two ports. The plain data port sends an ordinary word. The address port sends the same frame with its mark bit set. Each frame goes out one bit per bit-enable pulse. Software can also ask the block to send a whole frame of idle level, a preamble (also high), or a break (low).

Software polls two flags. The holding-empty flag shows that another word may be written. The transmitter-empty flag shows that both stages are empty. While transmitter-empty is set, a new word skips the holding register and starts on the line at once. Receive-side error flags enter as inputs. They are gated by a stored enable into a receive-exception interrupt request.

Top module: `sertx_stat`

## Requirements
- R1: After the asynchronous reset the status word reads 0x000003, `txd` is high, and the exception enable is cleared.
- R2: Status bit 0 is transmitter-empty, bit 1 is holding-empty, and bit 2 is high while the shifter is sending a frame. Bits 23 to 3 always read zero.
- R3: A write accepted while transmitter-empty is set loads the shift register directly. In the next cycle transmitter-empty is clear, holding-empty stays set, and `txd` carries the start bit.
- R4: A write accepted while the shifter is busy and holding-empty is set goes to the holding register. Holding-empty then clears in the next cycle.
- R5: A write made while holding-empty is clear is ignored, and the held word is the one that is later sent.
- R6: A frame is DATA_W+3 bits, one per `bit_en` cycle, in this order: start bit 0, the data bits LSB first, the mark bit (1 for an `wr_addr` write, 0 for a `wr_data` write), then stop bit 1. If both write strobes are high in the same cycle, the mark bit is 1.
- R7: When a frame ends and a word is held, the held word starts in the next cycle with no idle gap, and holding-empty is set. A write that arrives in the very cycle a frame ends, with nothing held, also follows with no gap.
- R8: When a frame ends with nothing held, transmitter-empty is set and `txd` returns high.
- R9: `seq_req` with `seq_kind` 01 (idle) or 10 (preamble) sends DATA_W+3 high bits, and with 11 (break) it sends DATA_W+3 low bits. Transmitter-empty is clear while the sequence is sent. The request is honoured only when transmitter-empty is set and no write is strobed in the same cycle. Kind 00 does nothing.
- R10: `irq_rx_exc` is high exactly when the exception enable is set, `rx_full` is high, and at least one of `rx_perr`, `rx_ferr` and `rx_ovr` is high. The enable is written through `cfg_wr`/`cfg_exc_en`.
- R11: `sw_rst` empties both stages synchronously and clears the exception enable. In the next cycle the status reads 0x000003 and `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| bit_en | input | 1 | One-cycle pulse that advances the line by one bit |
| wr_data | input | 1 | Write strobe for an ordinary word |
| wr_addr | input | 1 | Write strobe for a word sent with its mark bit set |
| wr_word | input | DATA_W | Word to transmit |
| seq_req | input | 1 | Request to send an idle, preamble or break frame |
| seq_kind | input | 2 | 01 idle, 10 preamble, 11 break, 00 none |
| cfg_wr | input | 1 | Write strobe for the exception enable |
| cfg_exc_en | input | 1 | Value written to the exception enable |
| rx_full | input | 1 | Receive data register full |
| rx_perr | input | 1 | Receive parity error |
| rx_ferr | input | 1 | Receive framing error |
| rx_ovr | input | 1 | Receive overrun |
| txd | output | 1 | Serial line, high when idle |
| irq_rx_exc | output | 1 | Receive-exception interrupt request |
| status | output | 24 | Read-only status word |

## Verification
A wrong internal state usually appears on the status word in the cycle after the write or frame end that caused it. For example, a held flag that never clears shows holding-empty stuck low, and a shifter that forgets it is busy shows transmitter-empty set while the line is still moving. Errors in word order or bit order show up on `txd` itself. A word taken from the wrong stage, or a write that was not ignored, is caught at the first bit that differs from the expected frame. A lost direct load or a bubble at a frame boundary shows in the count of busy cycles as soon as the line goes idle.

// File: rtl/sertx_stat.sv
module sertx_stat #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              bit_en,
  input  logic              wr_data,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              seq_req,
  input  logic [1:0]        seq_kind,
  input  logic              cfg_wr,
  input  logic              cfg_exc_en,
  input  logic              rx_full,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_ovr,
  output logic              txd,
  output logic              irq_rx_exc,
  output logic [23:0]       status
);
  localparam int FRAME = DATA_W + 3;
  localparam int CW    = $clog2(FRAME);

  logic [DATA_W:0]  dreg;
  logic             dfull, busy, exc_en;
  logic [FRAME-1:0] shreg;
  logic [CW-1:0]    cnt;

  logic wr_any, wr_ok, direct, seq_ok, done, trne, tdre;
  logic [FRAME-1:0] wr_frame, hold_frame, seq_frame;

  assign wr_any     = wr_data | wr_addr;
  assign tdre       = !dfull;
  assign trne       = !dfull && !busy;
  assign done       = busy && bit_en && (cnt == CW'(FRAME - 1));
  assign wr_ok      = wr_any && !dfull;
  assign direct     = wr_ok && (!busy || done);
  assign seq_ok     = seq_req && (seq_kind != 2'b00) && trne && !wr_any;
  assign wr_frame   = {1'b1, wr_addr, wr_word, 1'b0};
  assign hold_frame = {1'b1, dreg, 1'b0};
  assign seq_frame  = {FRAME{seq_kind != 2'b11}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg <= '0; dfull <= 1'b0; busy <= 1'b0; exc_en <= 1'b0;
      shreg <= '1; cnt <= '0;
    end else if (sw_rst) begin
      dfull <= 1'b0; busy <= 1'b0; exc_en <= 1'b0;
      shreg <= '1; cnt <= '0;
    end else begin
      if (cfg_wr) exc_en <= cfg_exc_en;
      if (done && dfull) begin
        shreg <= hold_frame; cnt <= '0; dfull <= 1'b0;
      end else if (direct) begin
        shreg <= wr_frame; cnt <= '0; busy <= 1'b1;
      end else if (seq_ok) begin
        shreg <= seq_frame; cnt <= '0; busy <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy && bit_en) begin
        shreg <= {1'b1, shreg[FRAME-1:1]};
        cnt   <= cnt + 1'b1;
      end
      if (wr_ok && !direct) begin
        dreg  <= {wr_addr, wr_word};
        dfull <= 1'b1;
      end
    end
  end

  assign txd        = busy ? shreg[0] : 1'b1;
  assign irq_rx_exc = exc_en & rx_full & (rx_perr | rx_ferr | rx_ovr);
  assign status     = {21'b0, busy, tdre, trne};

  // R3
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (wr_any && status[0]) |=> (status[2:0] == 3'b110 && !txd));

  // R5
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (wr_any && !status[1]) |=> (dreg == $past(dreg)));

  // R7
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (done && dfull) |=> (status[2] && status[1] && !txd));

  // R8
  frame_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (done && dfull == 1'b0 && !wr_any) |=> (status[0] && txd));

  // R9
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    seq_ok |=> (!status[0] && status[2]));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (status == 24'h3 && !irq_rx_exc));
endmodule

// File: tb/sertx_stat_tb_top.sv
`timescale 1ns/100ps
module sertx_stat_tb_top;
  localparam int DATA_W = 8;
  localparam int FRAME  = DATA_W + 3;

  logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0, bit_en = 1'b1;
  logic wr_data = 1'b0, wr_addr = 1'b0, seq_req = 1'b0;
  logic [DATA_W-1:0] wr_word = '0;
  logic [1:0] seq_kind = 2'b00;
  logic cfg_wr = 1'b0, cfg_exc_en = 1'b0;
  logic rx_full = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_ovr = 1'b0;
  logic txd, irq_rx_exc;
  logic [23:0] status;

  int total = 0, fails = 0, busy_cnt = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  sertx_stat #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bit_en(bit_en),
    .wr_data(wr_data), .wr_addr(wr_addr), .wr_word(wr_word),
    .seq_req(seq_req), .seq_kind(seq_kind), .cfg_wr(cfg_wr), .cfg_exc_en(cfg_exc_en),
    .rx_full(rx_full), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
    .txd(txd), .irq_rx_exc(irq_rx_exc), .status(status));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: one expected line bit per busy cycle (R6)
  always @(negedge clk) begin
    if (rst_n && status[2]) begin
      busy_cnt++;
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6: unexpected line bit got %0b expected none", txd);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (txd !== e) begin
          fails++;
          $display("FAIL R6: line bit got %0b expected %0b", txd, e);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic push_frame(bit mark, logic [DATA_W-1:0] w);
    exp_q.push_back(1'b0);
    for (int i = 0; i < DATA_W; i++) exp_q.push_back(w[i]);
    exp_q.push_back(mark);
    exp_q.push_back(1'b1);
  endtask

  task automatic push_level(bit lvl);
    for (int i = 0; i < FRAME; i++) exp_q.push_back(lvl);
  endtask

  task automatic wr(bit addr, logic [DATA_W-1:0] w);
    wr_data = !addr; wr_addr = addr; wr_word = w;
    step();
    wr_data = 1'b0; wr_addr = 1'b0;
  endtask

  task automatic seq(logic [1:0] k);
    seq_req = 1'b1; seq_kind = k;
    step();
    seq_req = 1'b0; seq_kind = 2'b00;
  endtask

  task automatic cfg(bit v);
    cfg_wr = 1'b1; cfg_exc_en = v;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!status[2]) break;
      step();
    end
  endtask

  task automatic set_rx(bit f, bit p, bit fr, bit o);
    rx_full = f; rx_perr = p; rx_ferr = fr; rx_ovr = o;
    step();
  endtask

  initial begin
    #(200000 * 4);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 reset status", status, 24'h3);
    chk("R1 reset txd", txd, 1);
    rx_full = 1; rx_perr = 1; step();
    chk("R1 enable cleared", irq_rx_exc, 0);
    rx_full = 0; rx_perr = 0;

    // direct load, held word, ignored write
    busy_cnt = 0;
    push_frame(0, 8'hA5); wr(0, 8'hA5);
    chk("R3 direct load status", status, 24'h6);
    chk("R3 start bit", txd, 0);
    push_frame(1, 8'h3C); wr(1, 8'h3C);
    chk("R4 held status", status, 24'h4);
    wr(0, 8'hFF);
    chk("R5 ignored write status", status, 24'h4);
    chk("R2 upper bits zero", status[23:3], 0);
    wait_idle();
    chk("R7 no gap busy cycles", busy_cnt, 2 * FRAME);
    chk("R8 idle status", status, 24'h3);
    chk("R8 idle line", txd, 1);

    // write landing on frame-end cycle
    busy_cnt = 0;
    push_frame(0, 8'h81); wr(0, 8'h81);
    repeat (FRAME - 1) step();
    push_frame(1, 8'h18); wr(1, 8'h18);
    chk("R7 frame-end write status", status, 24'h6);
    wait_idle();
    chk("R7 frame-end write busy cycles", busy_cnt, 2 * FRAME);

    // sequences
    push_level(1); seq(2'b01);
    chk("R9 idle clears trne", status, 24'h6);
    wait_idle();
    push_level(1); seq(2'b10);
    chk("R9 preamble clears trne", status, 24'h6);
    wait_idle();
    push_level(0); seq(2'b11);
    chk("R9 break line low", txd, 0);
    wait_idle();
    chk("R9 after break status", status, 24'h3);
    seq(2'b00);
    chk("R9 kind 00 no effect", status, 24'h3);
    busy_cnt = 0;
    push_frame(0, 8'h55); wr(0, 8'h55);
    seq(2'b11);
    wait_idle();
    chk("R9 seq while busy ignored", busy_cnt, FRAME);
    busy_cnt = 0;
    wr_data = 1; wr_word = 8'h0F; seq_req = 1; seq_kind = 2'b11;
    push_frame(0, 8'h0F);
    step();
    wr_data = 0; seq_req = 0; seq_kind = 2'b00;
    wait_idle();
    chk("R9 write wins over seq", busy_cnt, FRAME);

    // both strobes: mark set (R6)
    wr_data = 1; wr_addr = 1; wr_word = 8'hC3;
    push_frame(1, 8'hC3);
    step();
    wr_data = 0; wr_addr = 0;
    wait_idle();

    // interrupt
    cfg(1);
    set_rx(1, 1, 0, 0); chk("R10 parity", irq_rx_exc, 1);
    set_rx(1, 0, 1, 0); chk("R10 framing", irq_rx_exc, 1);
    set_rx(1, 0, 0, 1); chk("R10 overrun", irq_rx_exc, 1);
    set_rx(1, 0, 0, 0); chk("R10 no error", irq_rx_exc, 0);
    set_rx(0, 1, 1, 1); chk("R10 not full", irq_rx_exc, 0);
    cfg(0);
    set_rx(1, 1, 1, 1); chk("R10 disabled", irq_rx_exc, 0);
    cfg(1);
    chk("R10 re-enabled", irq_rx_exc, 1);

    // software reset mid-frame with a held word
    push_frame(0, 8'h11); wr(0, 8'h11);
    wr(0, 8'h22);
    step(); step();
    sw_rst = 1; exp_q.delete();
    step();
    sw_rst = 0;
    chk("R11 status after sw reset", status, 24'h3);
    chk("R11 line after sw reset", txd, 1);
    chk("R11 enable cleared", irq_rx_exc, 0);
    rx_full = 0; rx_perr = 0; rx_ferr = 0; rx_ovr = 0;
    push_frame(1, 8'h7E); wr(1, 8'h7E);
    wait_idle();
    chk("R6 all frames sent", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule